// File: doc/BRIEF.md
# Timer Channel Output Waveform Unit

This block is one channel of a general-purpose timer. A 16-bit counter counts down from a preload value whenever the channel is running and an external prescaler tick is high. When the count reaches zero, that is a timeout, and the next tick reloads the preload value. In compare mode, a compare event also fires when the count reaches the value held in the compare register. These two events drive a single output level through one of four output modes: off, toggle, force-low and force-high. In the off mode the pin driver is disabled.

Software reaches the channel through a small register port. It has a control word (mode, run, compare enable, interrupt enables), the preload value, the compare value and a status word. The status word holds three sticky event flags: timeout, gate and compare. It also holds the live gate level, the run state, the output level, an exact-match indication and the prescaler state. At the top sits an interrupt summary bit, which also drives the interrupt request output. The status word is captured on every clock edge. While a read of it is held, the capture stops, so the value does not change under the reader. If the mode is written while the run bit is clear, the output level takes its starting value at once.

Register map (addr_i): 0 control, 1 preload, 2 compare, 3 status. Control bits: [1:0] mode (00 off, 01 toggle, 10 force-low, 11 force-high), [2] run, [3] compare mode, [4] compare interrupt enable, [5] gate interrupt enable, [6] timeout interrupt enable.

Top module: `tmr_wave_top`

## Requirements
- R1: During reset and until the first edge after it, the status word reads 0x08FF when gate_ni is high and presc_i is 0xFF. out_oe_o, out_o and irq_o are 0.
- R2: A control write with bit 2 (run) clear sets out_o on the next edge. Toggle (01) and force-low (10) set it to 0, force-high (11) sets it to 1, and off (00) leaves it unchanged.
- R3: While run is set and tick_i is high, the counter steps down by one on each edge. Reaching 0 is a timeout. The next tick after a timeout reloads the preload value. While run is clear, the counter holds the preload value. A preload of N therefore gives a timeout every N+1 ticks.
- R4: Toggle mode (01) inverts out_o at each timeout when compare mode (control bit 3) is clear. When compare mode is set, it inverts out_o at each compare event only.
- R5: Force-low mode (10) clears out_o at a timeout. When compare mode is set, it also sets out_o at each compare event.
- R6: Force-high mode (11) sets out_o at a timeout. When compare mode is set, it also clears out_o at each compare event.
- R7: With a compare value of 0, the timeout and the compare event fall on the same edge and the timeout action wins. Force-low gives 0 and force-high gives 1.
- R8: In off mode out_oe_o is 0, and it is 1 in every other mode. Status bit 9 always shows the internal output level.
- R9: A timeout sets flag bit 14, a falling edge of gate_ni sets flag bit 13, and a compare event sets flag bit 12. Bit 15 and irq_o are the OR of each flag ANDed with its enable (bit 6, 5 and 4 of the control word).
- R10: A status write with a 1 in bit 14, 13 or 12 clears that flag, and a 0 leaves it unchanged. An event on the same edge as the clear keeps the flag set.
- R11: While stop_i is high, status writes clear no flag.
- R12: While re_i is high with addr_i = 3, rdata_o stays frozen. After re_i falls, the next edge refreshes the status word.
- R13: Status bits: 11 = gate_ni level, 10 = run, 8 = 1 when counter equals compare, [7:0] = presc_i. All of these are sampled at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Module stopped; blocks flag clearing |
| tick_i | input | 1 | Prescaler tick enabling one count step |
| gate_ni | input | 1 | Synchronised gate level, active low |
| presc_i | input | PSC_W | Prescaler state shown in the status word |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read in progress |
| addr_i | input | 2 | Register select |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| out_o | output | 1 | Timer output level |
| out_oe_o | output | 1 | Output driver enable (0 = high impedance) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the compare-at-zero collision. Both events land on the same edge, and the result only shows if the output level starts opposite to what the timeout forces. The bench therefore first presets the level with a stopped mode write. It then writes the opposite force mode together with run, so no preset happens, and samples out_o just after the fourth edge. The clear-versus-event race is set up the same way: a flag-clear write is placed on the exact edge where the counter reaches zero, counted from the run write.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
  typedef enum logic [1:0] {
    OM_OFF  = 2'b00,
    OM_TGL  = 2'b01,
    OM_LOW  = 2'b10,
    OM_HIGH = 2'b11
  } out_mode_e;

  localparam int CTRL_W   = 7;
  localparam int CB_RUN   = 2;
  localparam int CB_CMP   = 3;
  localparam int CB_IE_LO = 4;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_LOAD = 2'd1;
  localparam logic [1:0] RA_CMP  = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  localparam int FL_TC = 0;
  localparam int FL_TG = 1;
  localparam int FL_TO = 2;
  localparam int FL_N  = 3;
endpackage

// File: rtl/tmr_wave_cnt.sv
module tmr_wave_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             to_evt_o,
  output logic             cmp_evt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             step;

  assign step    = run_i & tick_i;
  assign cnt_nxt = (cnt_q == '0) ? load_i : cnt_q - 1'b1;

  // events flag the value the counter is about to take
  assign to_evt_o  = step & (cnt_nxt == '0);
  assign cmp_evt_o = step & cmp_en_i & (cnt_nxt == cmp_i);
  assign match_o   = (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= load_i;
    else if (tick_i) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
  import tmr_wave_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  out_mode_e mode_i,
  input  logic      cmp_en_i,
  input  logic      preset_i,
  input  out_mode_e preset_mode_i,
  input  logic      to_evt_i,
  input  logic      cmp_evt_i,
  output logic      lvl_o,
  output logic      oe_o
);
  logic lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (preset_i) begin
      unique case (preset_mode_i)
        OM_TGL, OM_LOW: lvl_d = 1'b0;
        OM_HIGH:        lvl_d = 1'b1;
        default:        lvl_d = lvl_q;
      endcase
    end else begin
      unique case (mode_i)
        OM_TGL: begin
          if (cmp_en_i ? cmp_evt_i : to_evt_i) lvl_d = ~lvl_q;
        end
        OM_LOW: begin
          // timeout action has priority on collision
          if (to_evt_i)                  lvl_d = 1'b0;
          else if (cmp_en_i & cmp_evt_i) lvl_d = 1'b1;
        end
        OM_HIGH: begin
          if (to_evt_i)                  lvl_d = 1'b1;
          else if (cmp_en_i & cmp_evt_i) lvl_d = 1'b0;
        end
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
  assign oe_o  = (mode_i != OM_OFF);
endmodule

// File: rtl/tmr_wave_stat.sv
module tmr_wave_stat
  import tmr_wave_pkg::*;
#(
  parameter int PSC_W = 8,
  localparam int DATA_W = PSC_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              gate_ni,
  input  logic [PSC_W-1:0]  presc_i,
  input  logic [FL_N-1:0]   evt_i,
  input  logic [FL_N-1:0]   ie_i,
  input  logic              clr_wr_i,
  input  logic [FL_N-1:0]   clr_mask_i,
  input  logic              hold_i,
  input  logic              run_i,
  input  logic              lvl_i,
  input  logic              match_i,
  output logic [FL_N-1:0]   flags_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] stat_o
);
  localparam logic [DATA_W-1:0] STAT_RST = {8'h08, {PSC_W{1'b1}}};

  logic [FL_N-1:0]   flag_q;
  logic [DATA_W-1:0] stat_q, stat_live;

  for (genvar i = 0; i < FL_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 flag_q[i] <= 1'b0;
      else if (evt_i[i])                           flag_q[i] <= 1'b1;
      else if (clr_wr_i && clr_mask_i[i] && !stop_i) flag_q[i] <= 1'b0;
    end
  end

  assign irq_o   = |(flag_q & ie_i);
  assign flags_o = flag_q;

  assign stat_live = {irq_o, flag_q[FL_TO], flag_q[FL_TG], flag_q[FL_TC],
                      gate_ni, run_i, lvl_i, match_i, presc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= STAT_RST;
    else if (!hold_i) stat_q <= stat_live;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/tmr_wave_top.sv
module tmr_wave_top
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8,
  localparam int DATA_W = PSC_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic              gate_ni,
  input  logic [PSC_W-1:0]  presc_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              out_o,
  output logic              out_oe_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q, cmp_q;
  logic              run, cmp_en, preset;
  out_mode_e         mode_q, preset_mode;
  logic              to_evt, cmp_evt, match, gate_q, tg_evt;
  logic [FL_N-1:0]   evts, flags;
  logic [DATA_W-1:0] stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      gate_q <= 1'b1;
    end else begin
      gate_q <= gate_ni;
      if (we_i) begin
        unique case (addr_i)
          RA_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
          RA_LOAD: load_q <= wdata_i[CNT_W-1:0];
          RA_CMP:  cmp_q  <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign mode_q      = out_mode_e'(ctrl_q[1:0]);
  assign run         = ctrl_q[CB_RUN];
  assign cmp_en      = ctrl_q[CB_CMP];
  assign preset      = we_i && (addr_i == RA_CTRL) && !wdata_i[CB_RUN];
  assign preset_mode = out_mode_e'(wdata_i[1:0]);
  assign tg_evt      = gate_q & ~gate_ni;

  tmr_wave_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick_i),
    .cmp_en_i  (cmp_en),
    .load_i    (load_q),
    .cmp_i     (cmp_q),
    .to_evt_o  (to_evt),
    .cmp_evt_o (cmp_evt),
    .match_o   (match)
  );

  tmr_wave_out u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_q),
    .cmp_en_i      (cmp_en),
    .preset_i      (preset),
    .preset_mode_i (preset_mode),
    .to_evt_i      (to_evt),
    .cmp_evt_i     (cmp_evt),
    .lvl_o         (out_o),
    .oe_o          (out_oe_o)
  );

  always_comb begin
    evts        = '0;
    evts[FL_TO] = to_evt;
    evts[FL_TG] = tg_evt;
    evts[FL_TC] = cmp_evt;
  end

  tmr_wave_stat #(.PSC_W(PSC_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (stop_i),
    .gate_ni    (gate_ni),
    .presc_i    (presc_i),
    .evt_i      (evts),
    .ie_i       ({ctrl_q[CB_IE_LO+2], ctrl_q[CB_IE_LO+1], ctrl_q[CB_IE_LO]}),
    .clr_wr_i   (we_i && (addr_i == RA_STAT)),
    .clr_mask_i (wdata_i[DATA_W-2 -: FL_N]),
    .hold_i     (re_i && (addr_i == RA_STAT)),
    .run_i      (run),
    .lvl_i      (out_o),
    .match_i    (match),
    .flags_o    (flags),
    .irq_o      (irq_o),
    .stat_o     (stat)
  );

  always_comb begin
    unique case (addr_i)
      RA_CTRL: rdata_o = DATA_W'(ctrl_q);
      RA_LOAD: rdata_o = DATA_W'(load_q);
      RA_CMP:  rdata_o = DATA_W'(cmp_q);
      default: rdata_o = stat;
    endcase
  end
endmodule

// File: rtl/tmr_wave_chk.sv
module tmr_wave_chk
  import tmr_wave_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              we_i,
  input logic              re_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              out_o,
  input logic              out_oe_o,
  input logic              irq_o,
  input logic [1:0]        mode_bits,
  input logic [FL_N-1:0]   flags,
  input logic [FL_N-1:0]   evts
);
  // R2
  preset_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RA_CTRL && !wdata_i[CB_RUN] && wdata_i[1:0] == 2'b11) |=> out_o);

  // R8
  off_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_bits == 2'b00) |-> !out_oe_o);

  // R9
  to_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evts[FL_TO] |=> flags[FL_TO]);

  // R9
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags == '0) |-> !irq_o);

  // R10
  to_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == RA_STAT && wdata_i[DATA_W-2] && !stop_i && !evts[FL_TO])
      |=> !flags[FL_TO]);

  // R11
  stop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && flags[FL_TO]) |=> flags[FL_TO]);

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == RA_STAT && $past(re_i && addr_i == RA_STAT && rst_ni))
      |-> $stable(rdata_o));
endmodule

bind tmr_wave_top tmr_wave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stop_i    (stop_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .out_o     (out_o),
  .out_oe_o  (out_oe_o),
  .irq_o     (irq_o),
  .mode_bits (ctrl_q[1:0]),
  .flags     (flags),
  .evts      (evts)
);

// File: tb/tmr_wave_top_bench.sv
`timescale 1ns/1ps
module tmr_wave_top_bench;
  localparam int DW = 16;
  // control encodings
  localparam logic [15:0] M_OFF = 16'h0, M_TGL = 16'h1, M_LOW = 16'h2, M_HIGH = 16'h3;
  localparam logic [15:0] C_RUN = 16'h4, C_CMP = 16'h8, C_IE_TO = 16'h40;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stop_i = 1'b0, tick_i = 1'b1, gate_ni = 1'b1;
  logic [7:0]    presc_i = 8'hFF;
  logic          we_i = 1'b0, re_i = 1'b0;
  logic [1:0]    addr_i = 2'd0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          out_o, out_oe_o, irq_o;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tmr_wave_top u_tmr_wave_top (
    .clk_i(clk), .rst_ni(rst_ni), .stop_i(stop_i), .tick_i(tick_i),
    .gate_ni(gate_ni), .presc_i(presc_i), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .out_o(out_o), .out_oe_o(out_oe_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    step(1);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd_stat(output logic [15:0] v);
    addr_i = 2'd3;
    step(1);
    v = rdata_o;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; addr_i = 2'd3;
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", rdata_o, 16'h08FF);
    check("R1 oe", out_oe_o, 0);
    check("R1 out", out_o, 0);
    check("R1 irq", irq_o, 0);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_preset;
    wr(2'd0, M_HIGH); check("R2 high preset", out_o, 1);
    check("R8 oe on", out_oe_o, 1);
    wr(2'd0, M_LOW);  check("R2 low preset", out_o, 0);
    wr(2'd0, M_HIGH); wr(2'd0, M_TGL);
    check("R2 toggle preset", out_o, 0);
    wr(2'd0, M_OFF);  check("R2 off keeps", out_o, 0);
  endtask

  task automatic t_toggle_plain;
    wr(2'd1, 16'd3);
    wr(2'd0, M_TGL);
    wr(2'd0, M_TGL | C_RUN);
    step(2); check("R3 no timeout yet", out_o, 0);
    step(1); check("R4 toggle at timeout", out_o, 1);
    step(3); check("R3 period hold", out_o, 1);
    step(1); check("R4 second toggle", out_o, 0);
    wr(2'd0, M_OFF);
  endtask

  task automatic t_force_plain;
    wr(2'd0, M_HIGH);
    wr(2'd0, M_LOW | C_RUN);
    step(2); check("R5 before timeout", out_o, 1);
    step(1); check("R5 low at timeout", out_o, 0);
    wr(2'd0, M_LOW);
    wr(2'd0, M_HIGH | C_RUN);
    step(2); check("R6 before timeout", out_o, 0);
    step(1); check("R6 high at timeout", out_o, 1);
    wr(2'd0, M_OFF);
  endtask

  task automatic t_cmp_modes;
    wr(2'd1, 16'd7); wr(2'd2, 16'd4);
    wr(2'd0, M_LOW | C_CMP);
    wr(2'd0, M_LOW | C_CMP | C_RUN);
    step(2); check("R5 cmp before", out_o, 0);
    step(1); check("R5 set at compare", out_o, 1);
    step(3); check("R5 hold", out_o, 1);
    step(1); check("R5 clear at timeout", out_o, 0);
    step(4); check("R5 set again", out_o, 1);
    wr(2'd0, M_HIGH | C_CMP);
    wr(2'd0, M_HIGH | C_CMP | C_RUN);
    step(3); check("R6 clear at compare", out_o, 0);
    step(4); check("R6 set at timeout", out_o, 1);
    wr(2'd0, M_TGL | C_CMP);
    wr(2'd0, M_TGL | C_CMP | C_RUN);
    step(3); check("R4 cmp toggle", out_o, 1);
    step(4); check("R4 timeout ignored in cmp mode", out_o, 1);
    step(4); check("R4 cmp toggle again", out_o, 0);
    wr(2'd0, M_OFF);
  endtask

  task automatic t_collide;
    wr(2'd1, 16'd3); wr(2'd2, 16'd0);
    wr(2'd0, M_HIGH | C_CMP);
    wr(2'd0, M_LOW | C_CMP | C_RUN);
    step(3); check("R7 low wins", out_o, 0);
    wr(2'd0, M_LOW | C_CMP);
    wr(2'd0, M_HIGH | C_CMP | C_RUN);
    step(3); check("R7 high wins", out_o, 1);
    wr(2'd0, M_OFF);
  endtask

  task automatic t_flags;
    logic [15:0] v;
    wr(2'd2, 16'h00AA);
    check("R8 oe off", out_oe_o, 0);
    wr(2'd3, 16'h7000);
    wr(2'd0, C_IE_TO | C_RUN);
    step(2); check("R9 irq before", irq_o, 0);
    step(1); check("R9 irq at timeout", irq_o, 1);
    wr(2'd0, C_IE_TO);
    rd_stat(v); check("R13 status word", v, 16'hCAFF);
    check("R8 out mirrored while off", v[9], 1);
    wr(2'd3, 16'h0000); check("R10 zero write keeps", irq_o, 1);
    stop_i = 1'b1;
    wr(2'd3, 16'h4000); check("R11 stopped keeps", irq_o, 1);
    stop_i = 1'b0;
    wr(2'd3, 16'h4000); check("R10 clear", irq_o, 0);
    wr(2'd0, C_RUN);
    step(3); check("R9 masked", irq_o, 0);
    wr(2'd0, C_IE_TO); check("R9 enable late", irq_o, 1);
    wr(2'd3, 16'h7000);
    wr(2'd0, C_IE_TO | C_RUN);
    step(2);
    wr(2'd3, 16'h4000); check("R10 event wins", irq_o, 1);
    wr(2'd0, M_OFF);
    wr(2'd3, 16'h7000); check("R10 cleared", irq_o, 0);
  endtask

  task automatic t_freeze;
    logic [15:0] v0;
    wr(2'd0, C_RUN);
    addr_i = 2'd3; re_i = 1'b1;
    #0.5; v0 = rdata_o;
    check("R12 start clear", v0[14], 0);
    step(5); check("R12 frozen", rdata_o, v0);
    re_i = 1'b0;
    step(1); check("R12 refreshed", rdata_o[14], 1);
    wr(2'd0, M_OFF);
    wr(2'd3, 16'h7000);
  endtask

  task automatic t_gate;
    logic [15:0] v;
    presc_i = 8'h5A; gate_ni = 1'b0;
    step(1);
    rd_stat(v); check("R13 gate flag/TGL/presc", v, 16'h225A);
    wr(2'd2, 16'd3);
    step(1);
    rd_stat(v); check("R13 COM match", v, 16'h235A);
    gate_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_preset();
    t_toggle_plain();
    t_force_plain();
    t_cmp_modes();
    t_collide();
    t_flags();
    t_freeze();
    t_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule